// File: doc/BRIEF.md
# Selectable PRBS and Pattern Generator

This block produces a serial test stream, one bit per clock, for exercising a link or a pattern checker. Three sources are available: a short pseudo-random sequence (PRBS7, polynomial x^7 + x^6 + 1), a long one (PRBS31, polynomial x^31 + x^28 + 1), and a 64-bit word supplied on an input port that is sent over and over. The two pseudo-random engines are Fibonacci shift registers that start from an all-ones seed. The output can be sent in true or complemented polarity. Software control values arrive as plain input ports.

A small controller holds the active source as an enumerated state: ST_P7, ST_P31 or ST_USER. On reset the state is loaded from the mode input. On every enabled cycle, if the mode input names a source other than the current state, the controller moves to that state and re-seeds the new source in the same cycle. If the mode names the current source, the state stays put. While the enable is low, no state changes. A mode change made while disabled is therefore applied on the first enabled cycle.

The polarity input is active-high "true polarity". If the port is tied low or left at its default of 0, the PRBS output is complemented, which gives the inverted PRBS31 that telecom test practice expects.

Top module: `testpat_gen`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) drives dout and dout_vld to 0. It seeds both shift registers to all ones, points the word index at bit 63, and loads the state from mode.
- R2: dout_vld equals the value en had at the previous clock edge. It is 0 on the cycle after a reset edge.
- R3: Mode code 0 selects PRBS7 (ST_P7), code 1 selects PRBS31 (ST_P31), and codes 2 and 3 both select the user word (ST_USER).
- R4: In PRBS7 the output is the top bit of a 7-bit register. That register shifts toward the top and takes in bit6 XOR bit5. From the seed, the true-polarity output starts with seven 1s, obeys o[n+7] = o[n] XOR o[n+1], and repeats every 127 bits.
- R5: In PRBS31 the output is the top bit of a 31-bit register with feedback bit30 XOR bit27. From the seed, the true-polarity output starts with thirty-one 1s and obeys o[n+31] = o[n] XOR o[n+3].
- R6: In user mode, the bits of user_pat are sent from bit 63 down to bit 0 and then wrap to bit 63. The word is read live on each enabled cycle.
- R7: In a PRBS mode, dout is the sequence bit when prbs_true_pol is 1 and its complement when prbs_true_pol is 0. With the port at 0, PRBS31 starts with thirty-one 0s.
- R8: prbs_true_pol has no effect in user mode.
- R9: An enabled cycle whose mode names a different source restarts that source from its seed in that same cycle: the first bit is the seed bit, and the word index restarts at 63. Switching between codes 2 and 3 does not restart the word.
- R10: While en is low, dout, the shift registers and the word index all hold. Generation resumes exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generate one bit on this cycle |
| mode | input | 2 | Source select: 0 PRBS7, 1 PRBS31, 2 or 3 user word |
| prbs_true_pol | input | 1 | 1 sends PRBS in true polarity, 0 complements it |
| user_pat | input | 64 | Repeating user word, sent bit 63 first |
| dout | output | 1 | Serial output bit |
| dout_vld | output | 1 | dout holds a newly generated bit |

## Verification
The stream is checked against a reference model that rebuilds each PRBS from its recurrence over past output bits and walks the user word with its own index. It is run with the enable held high, with enable gaps, and with the polarity toggling during PRBS31 and during user mode; these separate correct holding from skipped or repeated bits, and a live polarity path from one that leaks into user mode. Mode changes are made both while enabled and while disabled, including the 2-to-3 switch, to tell a proper restart from a missing or spurious one. The user word is also changed during a run, and the run ends with a mid-stream reset, so that a pattern latched at restart and incorrect reset seeding both show up as output mismatches.

// File: rtl/testpat_pkg.sv
package testpat_pkg;

    // Active source of the generator
    typedef enum logic [1:0] {
        ST_P7   = 2'd0,
        ST_P31  = 2'd1,
        ST_USER = 2'd2
    } eng_st_t;

    // Mode codes: 0 short PRBS, 1 long PRBS, 2/3 user word (R3)
    function automatic eng_st_t mode_to_st(input logic [1:0] m);
        eng_st_t s;
        unique case (m)
            2'd0:    s = ST_P7;
            2'd1:    s = ST_P31;
            default: s = ST_USER;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/testpat_ctrl.sv
module testpat_ctrl
    import testpat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] mode,
    output eng_st_t    tgt,
    output logic       reseed,
    output logic       step_p7,
    output logic       step_p31,
    output logic       step_usr,
    output logic       ld_p7,
    output logic       ld_p31,
    output logic       ld_usr
);

    eng_st_t st;

    assign tgt    = mode_to_st(mode);
    // R9: moving to another source restarts it on the same enabled cycle
    assign reseed = en && (tgt != st);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= mode_to_st(mode);
        end else if (en) begin
            st <= tgt;
        end
    end

    // Per-engine strobes
    always_comb begin
        step_p7  = 1'b0;
        step_p31 = 1'b0;
        step_usr = 1'b0;
        unique case (tgt)
            ST_P7:   step_p7  = en;
            ST_P31:  step_p31 = en;
            ST_USER: step_usr = en;
            default: ;
        endcase
        ld_p7  = reseed && step_p7;
        ld_p31 = reseed && step_p31;
        ld_usr = reseed && step_usr;
    end

endmodule

// File: rtl/testpat_lfsr.sv
module testpat_lfsr #(
    parameter int LEN = 7,
    parameter int TAP = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic           load,
    output logic           bit_o,
    output logic [LEN-1:0] state_o
);

    localparam logic [LEN-1:0] SEED = '1;

    logic [LEN-1:0] state;
    logic [LEN-1:0] base;
    logic [LEN-1:0] nxt;

    // A load takes the seed as the current value, so its bit leaves this cycle
    always_comb begin
        base  = load ? SEED : state;
        bit_o = base[LEN-1];
        nxt   = {base[LEN-2:0], base[LEN-1] ^ base[TAP-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (step) begin
            state <= nxt;
        end
    end

    assign state_o = state;

endmodule

// File: rtl/testpat_word_ser.sv
module testpat_word_ser #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              load,
    input  logic [WORD_W-1:0] pat,
    output logic              bit_o
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] nxt;

    // R6: top bit first, wrap from 0 back to the top
    always_comb begin
        base  = load ? LAST : idx;
        bit_o = pat[base];
        nxt   = (base == '0) ? LAST : base - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= LAST;
        end else if (step) begin
            idx <= nxt;
        end
    end

endmodule

// File: rtl/testpat_gen.sv
module testpat_gen
    import testpat_pkg::*;
#(
    parameter int SHORT_LEN = 7,
    parameter int SHORT_TAP = 6,
    parameter int LONG_LEN  = 31,
    parameter int LONG_TAP  = 28,
    parameter int WORD_W    = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic              prbs_true_pol,
    input  logic [WORD_W-1:0] user_pat,
    output logic              dout,
    output logic              dout_vld
);

    eng_st_t              tgt;
    logic                 reseed;
    logic                 tgt_is_user;
    logic                 step_p7, step_p31, step_usr;
    logic                 ld_p7, ld_p31, ld_usr;
    logic                 bit_p7, bit_p31, bit_usr;
    logic [SHORT_LEN-1:0] p7_state;
    logic [LONG_LEN-1:0]  p31_state;
    logic                 sel_bit;
    logic                 flip;

    testpat_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .mode     (mode),
        .tgt      (tgt),
        .reseed   (reseed),
        .step_p7  (step_p7),
        .step_p31 (step_p31),
        .step_usr (step_usr),
        .ld_p7    (ld_p7),
        .ld_p31   (ld_p31),
        .ld_usr   (ld_usr)
    );

    testpat_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP)) u_p7 (
        .clk     (clk),
        .rst     (rst),
        .step    (step_p7),
        .load    (ld_p7),
        .bit_o   (bit_p7),
        .state_o (p7_state)
    );

    testpat_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP)) u_p31 (
        .clk     (clk),
        .rst     (rst),
        .step    (step_p31),
        .load    (ld_p31),
        .bit_o   (bit_p31),
        .state_o (p31_state)
    );

    testpat_word_ser #(.WORD_W(WORD_W)) u_word (
        .clk   (clk),
        .rst   (rst),
        .step  (step_usr),
        .load  (ld_usr),
        .pat   (user_pat),
        .bit_o (bit_usr)
    );

    assign tgt_is_user = (tgt == ST_USER);

    // Source select and polarity (R7, R8)
    always_comb begin
        flip = 1'b0;
        unique case (tgt)
            ST_P7:   begin sel_bit = bit_p7;  flip = !prbs_true_pol; end
            ST_P31:  begin sel_bit = bit_p31; flip = !prbs_true_pol; end
            ST_USER: sel_bit = bit_usr;
            default: sel_bit = 1'b0;
        endcase
    end

    // Output register (R1, R2, R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            dout     <= 1'b0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= en;
            if (en) begin
                dout <= sel_bit ^ flip;
            end
        end
    end

endmodule

// File: rtl/testpat_chk.sv
module testpat_chk #(
    parameter int SHORT_LEN = 7,
    parameter int LONG_LEN  = 31,
    parameter int WORD_W    = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 prbs_true_pol,
    input logic [WORD_W-1:0]    user_pat,
    input logic                 dout,
    input logic                 dout_vld,
    input logic                 reseed,
    input logic                 tgt_is_user,
    input logic [SHORT_LEN-1:0] p7_state,
    input logic [LONG_LEN-1:0]  p31_state
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    AST_VLD_TRACKS_EN: assert property (@(posedge clk) disable iff (rst)
        !rst_q |-> (dout_vld == $past(en))); // R2

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(dout) && !dout_vld)); // R10

    AST_P7_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        p7_state != '0); // R4

    AST_P31_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        p31_state != '0); // R5

    AST_PRBS_RESTART: assert property (@(posedge clk) disable iff (rst)
        (reseed && !tgt_is_user) |=> (dout == $past(prbs_true_pol))); // R9

    AST_WORD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (reseed && tgt_is_user) |=> (dout == $past(user_pat[WORD_W-1]))); // R9

endmodule

bind testpat_gen testpat_chk #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN),
    .WORD_W    (WORD_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .prbs_true_pol (prbs_true_pol),
    .user_pat      (user_pat),
    .dout          (dout),
    .dout_vld      (dout_vld),
    .reseed        (reseed),
    .tgt_is_user   (tgt_is_user),
    .p7_state      (p7_state),
    .p31_state     (p31_state)
);

// File: tb/testpat_gen_test.sv
module testpat_gen_test;

    logic        clk = 1'b0;
    logic        rst, en, pol;
    logic [1:0]  mode;
    logic [63:0] upat;
    wire         dout, dout_vld;

    always #10 clk = ~clk;

    testpat_gen uut (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .mode          (mode),
        .prbs_true_pol (pol),
        .user_pat      (upat),
        .dout          (dout),
        .dout_vld      (dout_vld)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit got[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit armed = 0;
    int cls;
    bit hist[$];
    int uidx;
    bit exp_d, exp_v;

    function automatic int cls_of(input logic [1:0] m);
        return (m == 2'd0) ? 0 : ((m == 2'd1) ? 1 : 2);
    endfunction

    always @(posedge clk) begin
        int c, L, t, n;
        bit b;
        if (rst) begin
            exp_d = 0; exp_v = 0; cls = cls_of(mode);
            hist.delete(); uidx = 63; armed = 1;
        end else begin
            exp_v = en;
            if (en) begin
                c = cls_of(mode);
                if (c != cls) begin
                    cls = c; hist.delete(); uidx = 63;
                end
                if (cls == 2) begin
                    b = upat[uidx];
                    uidx = (uidx == 0) ? 63 : uidx - 1;
                    exp_d = b;
                end else begin
                    L = (cls == 0) ? 7 : 31;
                    t = (cls == 0) ? 1 : 3;
                    n = hist.size();
                    if (n < L) b = 1'b1;
                    else b = hist[n-L] ^ hist[n-L+t];
                    hist.push_back(b);
                    if (hist.size() > 31) void'(hist.pop_front());
                    exp_d = b ^ !pol;
                end
            end
        end
    end

    always @(negedge clk) begin
        string tag;
        if (armed && !done) begin
            chk(dout_vld === exp_v, "R2", "valid flag", dout_vld, exp_v);
            if (rst) tag = "R1";
            else if (!exp_v) tag = "R10";
            else if (cls == 0) tag = "R4";
            else if (cls == 1) tag = "R5";
            else tag = "R6";
            chk(dout === exp_d, tag, "model bit", dout, exp_d);
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic grab(input int n);
        got.delete();
        while (got.size() < n) begin
            @(negedge clk);
            if (dout_vld) got.push_back(dout);
        end
    endtask

    initial begin
        int bad;
        rst = 1; en = 0; mode = 2'd1; pol = 0;
        upat = 64'hF0E1_D2C3_B4A5_9687;
        repeat (3) @(negedge clk);
        chk(dout == 0 && dout_vld == 0, "R1", "reset outputs", {dout, dout_vld}, 0);
        rst = 0;
        @(negedge clk);

        // r7_ default polarity: PRBS31 comes out complemented
        en = 1;
        grab(40);
        bad = 0;
        for (int i = 0; i < 31; i++) if (got[i] != 0) bad++;
        chk(bad == 0, "R7", "inverted seed run", bad, 0);
        chk(got[31] == 1, "R5", "bit 31 of inverted PRBS31", got[31], 1);

        // R3 / R9: switch to PRBS7 in true polarity, check seed and period (R4)
        mode = 2'd0; pol = 1;
        grab(260);
        bad = 0;
        for (int i = 0; i < 7; i++) if (got[i] != 1) bad++;
        chk(bad == 0, "R9", "PRBS7 restart seed bits", bad, 0);
        bad = 0;
        for (int i = 0; i < 133; i++) if (got[i] != got[i+127]) bad++;
        chk(bad == 0, "R4", "PRBS7 period 127", bad, 0);
        bad = 0;
        for (int i = 0; i < 127; i++) bad += got[i];
        chk(bad == 64, "R3", "PRBS7 ones per period", bad, 64);

        // R7: polarity toggling during PRBS31 (model checks each bit)
        mode = 2'd1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            pol = (i % 7) < 3;
        end

        // R6 / R8: user word with polarity low then high
        mode = 2'd2; pol = 0;
        grab(130);
        bad = 0;
        for (int i = 0; i < 130; i++) if (got[i] != upat[63 - (i % 64)]) bad++;
        chk(bad == 0, "R6", "user word order with wrap", bad, 0);
        pol = 1;
        grab(64);
        bad = 0;
        for (int i = 0; i < 64; i++) if (got[i] != upat[63 - ((130 + i) % 64)]) bad++;
        chk(bad == 0, "R8", "polarity ignored in user mode", bad, 0);

        // R9: code 3 continues the same word without restart
        mode = 2'd3;
        grab(10);
        bad = 0;
        for (int i = 0; i < 10; i++) if (got[i] != upat[63 - ((194 + i) % 64)]) bad++;
        chk(bad == 0, "R9", "code 2 to 3 keeps position", bad, 0);

        // R10: enable gaps with mode changes while running
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            en = (i % 5) != 0;
            if (i == 100) mode = 2'd0;
            if (i == 200) mode = 2'd1;
        end

        // R9: mode change while disabled applies on the first enabled cycle
        en = 0; mode = 2'd0; pol = 1;
        repeat (5) @(negedge clk);
        chk(dout_vld == 0, "R10", "valid low while disabled", dout_vld, 0);
        en = 1;
        grab(7);
        bad = 0;
        for (int i = 0; i < 7; i++) if (got[i] != 1) bad++;
        chk(bad == 0, "R9", "deferred restart seed bits", bad, 0);

        // R6: live word changes during user mode
        mode = 2'd2;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (i % 17 == 0) upat = {upat[62:0], upat[63] ^ upat[60]} ^ 64'h0123_4567_89AB_CDEF;
        end

        // R1: reset in mid-stream, then default-polarity PRBS31 from seed
        mode = 2'd1; pol = 0; rst = 1;
        @(negedge clk);
        chk(dout == 0 && dout_vld == 0, "R1", "mid-run reset outputs", {dout, dout_vld}, 0);
        rst = 0;
        grab(31);
        bad = 0;
        for (int i = 0; i < 31; i++) if (got[i] != 0) bad++;
        chk(bad == 0, "R1", "reseeded after reset", bad, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule